// File: doc/BRIEF.md
# Two-wire register-pointer target for a clock/calendar block

This block is the serial-bus front end of a clock/calendar core. It watches an oversampled two-wire bus (clock line and data line, both sampled by the system clock), recognises its own 7-bit target address, and turns bus transfers into single-cycle read and write strobes on an eight-entry register file. The register file itself lives outside. Seven entries are clock registers and one is a control register. An internal pointer selects the entry. The pointer is loaded by the first byte after a write address and advances by one after each transferred byte. It wraps from the last entry to entry 0.

Three access patterns are supported. A write transfer loads the pointer and then stores any number of bytes. An addressed read loads the pointer in a write transfer and then switches direction with a repeated START. A current-address read simply starts reading at whatever the pointer holds. The block also gives the clock core a read-active flag while clock registers are being read out, so the core can hold off its update. A power-fail input aborts any transfer and clears the pointer. The bus is ignored for as long as that input stays high.

Top module: `rtcbus_target`

## Requirements
- R1: A START (data line falling while the clock line is high) begins a new address byte from any state. A STOP (data line rising while the clock line is high) returns the block to idle. Bits are taken on the clock line's rising edge, most significant bit first, and a ninth acknowledge bit follows each byte.
- R2: The block acknowledges (pulls the data line low during the ninth bit) an address byte whose upper seven bits equal 7'h68. A byte with any other address gets no acknowledge. The block then ignores the bus, with no acknowledge and no strobe, until the next START.
- R3: After an address byte with bit 0 = 0, the next byte is acknowledged and its low three bits load the pointer. The upper bits are ignored.
- R4: Each later byte of a write transfer is acknowledged. At the end of its acknowledge clock, the block issues a one-cycle `reg_wr` with `reg_addr` = pointer and `reg_wdata` = the byte, and the pointer then advances by one, wrapping from 7 to 0.
- R5: After an address byte with bit 0 = 1, the block issues a one-cycle `reg_rd` with `reg_addr` = pointer. It takes `reg_rdata` one cycle later and shifts that byte out MSB first. `reg_rd` and `reg_wr` are never high together.
- R6: In a read, the pointer advances by one (with wrap) and the next byte is fetched only when the master acknowledges. A master NACK ends the transfer, leaves the pointer unchanged and releases the data line.
- R7: A read started without a preceding pointer write returns the entry at the pointer left by the previous transfer.
- R8: While `pwr_fail` is high, the block releases the data line, clears the pointer to 0, issues no strobes and gives no acknowledges. A transfer cut by it never completes.
- R9: `rd_active` is high during a read transfer (from the read address acknowledge until STOP, START or NACK) while the pointer is below 7. It is low otherwise, and is always low during writes.
- R10: Both bus inputs pass two synchroniser flops and a filter that accepts a new level only after FILT_LEN (default 4) consecutive samples. A clock-line pulse of 2 cycles is not seen as a bit. The data-line pull-down is only turned on while the filtered clock line is low.
- R11: After reset, `sda_pull`, `reg_wr`, `reg_rd` and `rd_active` are 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| pwr_fail | input | 1 | Supply-loss indication; aborts and holds the block inactive |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line |
| sda_pull | output | 1 | 1 = drive the data line low (open drain) |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_rd | output | 1 | One-cycle register read request |
| reg_addr | output | 3 | Register index for either strobe |
| reg_wdata | output | 8 | Byte to write |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd` |
| rd_active | output | 1 | Clock registers are being read; core should defer its update |

## Verification
The assertions assume that the bus clock stays low for several system cycles after each falling edge, so that a pull-down turned on after the detected edge still falls inside the low phase. They also assume that the register file answers a read request one cycle later. The bench's master model holds each bus phase for 16 system clocks, well above the filter and synchroniser latency. It changes the data line only in the middle of the clock-low phase, except for the deliberate START, STOP and repeated-START edges. The register model returns read data on the cycle after `reg_rd`. The only short pulse driven is the deliberate 2-cycle clock glitch, which is kept below the filter length.

// File: rtl/rtcbus_pkg.sv
package rtcbus_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_RD_WAIT,
    ST_RD_CAP,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } bus_state_e;

  typedef enum logic [1:0] {
    BK_DEV,
    BK_PTR,
    BK_DATA
  } byte_kind_e;
endpackage

// File: rtl/rtcbus_sync.sv
module rtcbus_sync #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    meta;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= 2'b11;
      filt <= 1'b1;
      cnt  <= '0;
    end else begin
      meta <= {meta[0], raw};
      if (meta[1] == filt) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        filt <= meta[1];
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // a new filtered level must match the synchronised sample it was taken from
  assert_filter_follow_R10: assert property (@(posedge clk) disable iff (rst)
    (filt != $past(filt)) |-> ($past(meta[1]) == filt));

  assert_filter_count_R10: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(FILT_LEN));
endmodule

// File: rtl/rtcbus_edges.sv
module rtcbus_edges (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = !scl_q && scl_f;
  assign scl_fall  = scl_q && !scl_f;
  assign start_det = scl_q && scl_f && sda_q && !sda_f;
  assign stop_det  = scl_q && scl_f && !sda_q && sda_f;
endmodule

// File: rtl/rtcbus_target.sv
module rtcbus_target
  import rtcbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h68,
  parameter int         REG_COUNT  = 8,
  parameter int         CLOCK_REGS = 7,
  parameter int         FILT_LEN   = 4,
  localparam int        AW         = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_fail,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [AW-1:0]     reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              rd_active
);
  localparam int BCW = $clog2(BYTE_W + 1);

  // input conditioning: index 1 = clock line, index 0 = data line
  logic [1:0] raw_v, filt_v;
  assign raw_v = {scl_in, sda_in};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    rtcbus_sync #(.FILT_LEN(FILT_LEN)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .raw  (raw_v[g]),
      .filt (filt_v[g])
    );
  end

  logic scl_f, sda_f;
  assign scl_f = filt_v[1];
  assign sda_f = filt_v[0];

  logic scl_rise, scl_fall, start_det, stop_det;

  rtcbus_edges u_edges (
    .clk       (clk),
    .rst       (rst),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  bus_state_e        state;
  byte_kind_e        kind;
  logic [BCW-1:0]    bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [AW-1:0]     ptr;
  logic              read_sess;
  logic              mack;
  logic [AW-1:0]     next_ptr;

  assign next_ptr = (ptr == AW'(REG_COUNT - 1)) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      kind      <= BK_DEV;
      bitcnt    <= '0;
      shreg     <= '0;
      ptr       <= '0;
      read_sess <= 1'b0;
      mack      <= 1'b0;
      sda_pull  <= 1'b0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      rd_active <= 1'b0;
    end else begin
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      rd_active <= read_sess && ({1'b0, ptr} < (AW + 1)'(CLOCK_REGS));
      if (pwr_fail) begin
        state     <= ST_IDLE;
        ptr       <= '0;
        bitcnt    <= '0;
        sda_pull  <= 1'b0;
        read_sess <= 1'b0;
      end else if (start_det) begin
        state     <= ST_RX;
        kind      <= BK_DEV;
        bitcnt    <= '0;
        sda_pull  <= 1'b0;
        read_sess <= 1'b0;
      end else if (stop_det) begin
        state     <= ST_IDLE;
        sda_pull  <= 1'b0;
        read_sess <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_f};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == BCW'(BYTE_W)) begin
              bitcnt <= '0;
              if (kind == BK_DEV && shreg[BYTE_W-1:1] != DEV_ADDR) begin
                state <= ST_IGNORE;
              end else begin
                sda_pull <= 1'b1;
                state    <= ST_RX_ACK;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              case (kind)
                BK_DEV: begin
                  if (shreg[0]) begin
                    read_sess <= 1'b1;
                    reg_rd    <= 1'b1;
                    reg_addr  <= ptr;
                    state     <= ST_RD_WAIT;
                  end else begin
                    kind  <= BK_PTR;
                    state <= ST_RX;
                  end
                end
                BK_PTR: begin
                  ptr   <= shreg[AW-1:0];
                  kind  <= BK_DATA;
                  state <= ST_RX;
                end
                default: begin
                  reg_wr    <= 1'b1;
                  reg_addr  <= ptr;
                  reg_wdata <= shreg;
                  ptr       <= next_ptr;
                  state     <= ST_RX;
                end
              endcase
            end
          end
          ST_RD_WAIT: state <= ST_RD_CAP;
          ST_RD_CAP: begin
            shreg    <= reg_rdata;
            sda_pull <= !reg_rdata[BYTE_W-1];
            bitcnt   <= '0;
            state    <= ST_TX;
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == BCW'(BYTE_W - 1)) begin
                sda_pull <= 1'b0;
                state    <= ST_TX_ACK;
              end else begin
                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                sda_pull <= !shreg[BYTE_W-2];
                bitcnt   <= bitcnt + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack <= !sda_f;
            end else if (scl_fall) begin
              if (mack) begin
                ptr      <= next_ptr;
                reg_rd   <= 1'b1;
                reg_addr <= next_ptr;
                state    <= ST_RD_WAIT;
              end else begin
                read_sess <= 1'b0;
                state     <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_pf_abort_R8: assert property (@(posedge clk) disable iff (rst)
    pwr_fail |=> (!sda_pull && ptr == '0 && !reg_wr && !reg_rd));

  assert_pull_clock_low_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_f);

  assert_ignore_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE && $past(state) == ST_IGNORE) |-> (!sda_pull && !reg_wr && !reg_rd));

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_rd));

  assert_wr_advance_R4: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> (ptr != reg_addr));

  assert_wr_not_reading_R9: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> !rd_active);
endmodule

// File: tb/rtcbus_target_tb_top.sv
module rtcbus_target_tb_top;
  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_fail = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_in;
  logic       sda_pull, reg_wr, reg_rd, rd_active;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] rdata_q;

  logic [7:0] regs [8];
  logic [7:0] exp_regs [8];
  logic [2:0] last_addr;
  logic [7:0] last_data;
  int         wr_count;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #4 clk = !clk;

  assign sda_in = m_sda & !sda_pull;

  rtcbus_target dut_i (
    .clk       (clk),
    .rst       (rst),
    .pwr_fail  (pwr_fail),
    .scl_in    (m_scl),
    .sda_in    (sda_in),
    .sda_pull  (sda_pull),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (rdata_q),
    .rd_active (rd_active)
  );

  // register file model: read data returned one cycle after the request
  always @(posedge clk) begin
    if (rst) begin
      wr_count  <= 0;
      last_addr <= '0;
      last_data <= '0;
      rdata_q   <= '0;
    end else begin
      if (reg_wr) begin
        regs[reg_addr] <= reg_wdata;
        last_addr      <= reg_addr;
        last_data      <= reg_wdata;
        wr_count       <= wr_count + 1;
      end
      if (reg_rd) rdata_q <= regs[reg_addr];
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2 * Q);
  endtask

  task automatic put_bit(input bit b);
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(2 * Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output bit b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    b = sda_in; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(!mack);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired act=0 exp=1");
      finish_run();
    end
  end

  initial begin
    bit         ack;
    logic [7:0] d, v;
    int         wc;

    tick(5);
    rst = 1'b0;
    tick(5);
    // R11 reset state
    chk(!sda_pull && !reg_wr && !reg_rd && !rd_active, "R11", "reset outputs",
        {sda_pull, reg_wr, reg_rd, rd_active}, 0);

    // R2 foreign addresses: no acknowledge, later bytes ignored, no writes
    bus_start();
    send_byte(8'hA0, ack); chk(!ack, "R2", "foreign addr ack", ack, 0);
    send_byte(8'h03, ack); chk(!ack, "R2", "ignored byte ack", ack, 0);
    send_byte(8'h55, ack); chk(!ack, "R2", "ignored byte ack", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hD2, ack); chk(!ack, "R2", "near-miss addr ack", ack, 0);
    bus_stop();
    chk(wr_count == 0, "R2", "writes after foreign addr", wr_count, 0);

    // R3/R4 write sweep over every start pointer, three bytes each, wrapping
    for (int a = 0; a < 8; a++) begin
      bus_start();
      send_byte(8'hD0, ack); chk(ack, "R1", "write addr ack", ack, 1);
      send_byte(8'hF8 | 8'(a), ack); chk(ack, "R3", "pointer byte ack", ack, 1);
      for (int i = 0; i < 3; i++) begin
        v = 8'((a * 37 + i * 11 + 5) & 8'hFF);
        exp_regs[(a + i) % 8] = v;
        send_byte(v, ack);
        chk(ack, "R4", "data ack", ack, 1);
        chk(int'(last_addr) == (a + i) % 8, "R4", "write address", last_addr, (a + i) % 8);
        chk(last_data == v, "R4", "write data", last_data, v);
      end
      bus_stop();
    end
    chk(wr_count == 24, "R4", "write count", wr_count, 24);

    // R10 a 2-cycle clock glitch before a data byte must not count as a bit
    bus_start();
    send_byte(8'hD0, ack);
    send_byte(8'h02, ack);
    m_scl = 1'b1; tick(2); m_scl = 1'b0; tick(Q);
    send_byte(8'h5A, ack);
    exp_regs[2] = 8'h5A;
    chk(ack && last_addr == 3'd2 && last_data == 8'h5A, "R10", "glitch-filtered write",
        {last_addr, last_data}, {3'd2, 8'h5A});
    bus_stop();

    // R5/R6/R7/R9 addressed reads then current-address reads from every pointer
    for (int a = 0; a < 8; a++) begin
      bus_start();
      send_byte(8'hD0, ack);
      send_byte(8'(a), ack);
      bus_rstart();
      send_byte(8'hD1, ack); chk(ack, "R5", "read addr ack", ack, 1);
      chk(rd_active == (a != 7), "R9", "read-active flag", rd_active, a != 7);
      for (int i = 0; i < 3; i++) begin
        recv_byte(i < 2, d);
        chk(d == exp_regs[(a + i) % 8], "R5", "read data", d, exp_regs[(a + i) % 8]);
      end
      chk(!rd_active, "R6", "flag after NACK", rd_active, 0);
      bus_stop();
      chk(!rd_active, "R9", "flag after STOP", rd_active, 0);
      bus_start();
      send_byte(8'hD1, ack);
      recv_byte(1'b0, d);
      chk(d == exp_regs[(a + 2) % 8], "R7", "current-address read", d, exp_regs[(a + 2) % 8]);
      bus_stop();
    end

    // R8 power fail clears the pointer
    bus_start();
    send_byte(8'hD0, ack);
    send_byte(8'h05, ack);
    bus_stop();
    pwr_fail = 1'b1; tick(10);
    chk(!sda_pull, "R8", "pull during power fail", sda_pull, 0);
    pwr_fail = 1'b0; tick(10);
    bus_start();
    send_byte(8'hD1, ack);
    recv_byte(1'b0, d);
    chk(d == exp_regs[0], "R8", "pointer cleared", d, exp_regs[0]);
    bus_stop();

    // R8 abort in the middle of a data byte
    wc = wr_count;
    bus_start();
    send_byte(8'hD0, ack);
    send_byte(8'h03, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    pwr_fail = 1'b1;
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    get_bit(ack);
    chk(ack, "R8", "no ack while power fail (line high)", ack, 1);
    pwr_fail = 1'b0;
    bus_stop();
    chk(wr_count == wc, "R8", "aborted write", wr_count, wc);

    // R8 a complete transfer while power fail is held is ignored
    pwr_fail = 1'b1;
    bus_start();
    send_byte(8'hD0, ack); chk(!ack, "R8", "addr ack under power fail", ack, 0);
    send_byte(8'h04, ack);
    send_byte(8'h77, ack);
    bus_stop();
    pwr_fail = 1'b0; tick(10);
    chk(wr_count == wc, "R8", "writes under power fail", wr_count, wc);
    bus_start();
    send_byte(8'hD1, ack);
    recv_byte(1'b0, d);
    chk(d == exp_regs[0], "R8", "pointer still cleared", d, exp_regs[0]);
    bus_stop();

    done = 1'b1;
    finish_run();
  end
endmodule